// File: doc/BRIEF.md
# Mesh Node Route Selector

This block makes the forwarding decision for one node of a two-dimensional grid of processing cores. The destination of every transaction is coded in its 32-bit address. The upper six bits give the target row and the next six bits give the target column. The node compares these coordinates with its own position and picks exactly one of five output ports: north, south, east, west or the local core. Routing is dimension-ordered. The request first travels horizontally until it reaches the target column, and only then travels vertically until it reaches the target row.

A node on the boundary of the chip uses its boundary-facing port as an off-chip link. The output marks such a choice as leaving the chip. A board may leave any of these links unconnected. Each side therefore has an enable bit, and a request routed to a disabled boundary link is consumed and discarded. A counter records each request discarded this way, so that a request that would wait forever for a reply can be traced. The node position, the boundary flags and the link enables come from static pins and are latched while reset is asserted.

The decision is registered, which gives one cycle of latency. A registered result stays on the outputs until the chosen port accepts it.

Top module: `mesh_route_sel`

## Requirements
- R1: The destination column is address bits 25:20 and is compared first. If it is greater than the node's column the request leaves east (out_valid bit 2). If it is smaller the request leaves west (bit 3), whatever the row.
- R2: If the columns are equal, the destination row (address bits 31:26) decides. A smaller row goes north (bit 0) and a larger row goes south (bit 1).
- R3: If both the row and the column equal the node's position, the request goes to the local port (bit 4).
- R4: out_valid is one-hot or all zero, with bit order north, south, east, west, local.
- R5: A request accepted at a clock edge appears on the outputs right after that edge, with its address, write flag and payload unchanged.
- R6: While the chosen port's ready is low, the output port choice and the payload hold steady and in_ready stays low.
- R7: in_ready is high when no request is held, or when the held request leaves in the same cycle. Back-to-back transfers then flow at one per cycle.
- R8: out_offchip is high exactly when the chosen port faces a side flagged as a chip boundary (side_flags bit order north, south, east, west).
- R9: A request routed to a boundary side whose link_en bit (same bit order) is low is accepted and discarded. No output is raised, and drop_count rises by one on the following cycle.
- R10: link_en bits have no effect for sides that are not chip boundaries.
- R11: cfg_row, cfg_col, side_flags and link_en are latched only while rst is high. Later changes to them have no effect.
- R12: During and directly after reset, out_valid is zero, drop_count is zero and in_ready is low while rst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches the static configuration |
| cfg_row | input | 6 | Node row position pins |
| cfg_col | input | 6 | Node column position pins |
| side_flags | input | 4 | Chip-boundary flags, N/S/E/W |
| link_en | input | 4 | Off-chip link present, N/S/E/W |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle |
| in_addr | input | 32 | Request address carrying destination row/column |
| in_write | input | 1 | Write (1) or read (0) |
| in_data | input | DATA_W | Payload |
| out_valid | output | 5 | One-hot port choice N,S,E,W,L |
| out_ready | input | 5 | Per-port ready |
| out_addr | output | 32 | Held address |
| out_write | output | 1 | Held write flag |
| out_data | output | DATA_W | Held payload |
| out_offchip | output | 1 | Chosen port is an off-chip link |
| drop_count | output | CNT_W | Requests discarded at disabled links |

## Verification
The hardest case to reach from the ports is a dropped request that arrives while an earlier request is still held. For that case the discard and the departure of the held request happen in the same cycle. The stimulus places the node at a corner with one boundary link disabled. It then streams random addresses clustered around the node's own coordinates while out_ready toggles randomly, so drops land both on an empty stage and on a stage that is draining. A second configuration latched at reset, with the pins changed afterwards, shows that the pin values are captured only during reset.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    localparam int ADDR_W  = 32;
    localparam int COORD_W = 6;
    localparam int ROW_LSB = 26;
    localparam int COL_LSB = 20;
    localparam int NSIDE   = 4;
    localparam int NPORT   = NSIDE + 1;

    typedef enum logic [2:0] {
        PORT_N = 3'd0,
        PORT_S = 3'd1,
        PORT_E = 3'd2,
        PORT_W = 3'd3,
        PORT_L = 3'd4
    } port_e;

    typedef struct packed {
        logic [COORD_W-1:0] row;
        logic [COORD_W-1:0] col;
    } coord_t;

    function automatic coord_t addr_coord(input logic [ADDR_W-1:0] a);
        coord_t c;
        c.row = a[ROW_LSB +: COORD_W];
        c.col = a[COL_LSB +: COORD_W];
        return c;
    endfunction

    function automatic logic [NPORT-1:0] port_vec(input port_e p);
        logic [NPORT-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/mrs_decide.sv
module mrs_decide
    import mrs_pkg::*;
(
    input  coord_t             own,
    input  logic [ADDR_W-1:0]  addr,
    output port_e              dir
);
    coord_t dst;

    always_comb begin
        dst = addr_coord(addr);
        if (dst.col > own.col)       dir = PORT_E;
        else if (dst.col < own.col)  dir = PORT_W;
        else if (dst.row < own.row)  dir = PORT_N;
        else if (dst.row > own.row)  dir = PORT_S;
        else                         dir = PORT_L;
    end
endmodule

// File: rtl/mrs_link_gate.sv
module mrs_link_gate
    import mrs_pkg::*;
(
    input  port_e             dir,
    input  logic [NSIDE-1:0]  side_q,
    input  logic [NSIDE-1:0]  en_q,
    output logic              offchip,
    output logic              drop
);
    logic [NSIDE-1:0] hit;

    for (genvar d = 0; d < NSIDE; d++) begin : g_side
        assign hit[d] = side_q[d] && (dir == port_e'(d));
    end

    assign offchip = |hit;
    assign drop    = |(hit & ~en_q);
endmodule

// File: rtl/mrs_drop_ctr.sv
module mrs_drop_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (bump) cnt <= cnt + 1'b1;
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/mrs_out_reg.sv
module mrs_out_reg
    import mrs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  port_e             dir,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic              offchip,
    input  logic [NPORT-1:0]  out_ready,
    output logic              ready,
    output logic [NPORT-1:0]  out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic [DATA_W-1:0] out_data,
    output logic              out_offchip
);
    logic  held;
    port_e held_dir;
    logic  fire;

    assign fire      = held && out_ready[held_dir];
    assign ready     = !held || fire;
    assign out_valid = held ? port_vec(held_dir) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            held        <= 1'b0;
            held_dir    <= PORT_L;
            out_addr    <= '0;
            out_write   <= 1'b0;
            out_data    <= '0;
            out_offchip <= 1'b0;
        end else if (load) begin
            held        <= 1'b1;
            held_dir    <= dir;
            out_addr    <= addr;
            out_write   <= wr;
            out_data    <= data;
            out_offchip <= offchip;
        end else if (fire) begin
            held <= 1'b0;
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (|out_valid && !(|(out_valid & out_ready))) |=>
            ($stable(out_valid) && $stable(out_addr) && $stable(out_data) && $stable(out_write)));

    assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (out_addr == $past(addr) && out_data == $past(data)));
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
    import mrs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [5:0]          cfg_row,
    input  logic [5:0]          cfg_col,
    input  logic [3:0]          side_flags,
    input  logic [3:0]          link_en,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         in_addr,
    input  logic                in_write,
    input  logic [DATA_W-1:0]   in_data,
    output logic [4:0]          out_valid,
    input  logic [4:0]          out_ready,
    output logic [31:0]         out_addr,
    output logic                out_write,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_offchip,
    output logic [CNT_W-1:0]    drop_count
);
    coord_t           own_q;
    logic [NSIDE-1:0] side_q;
    logic [NSIDE-1:0] en_q;

    // static configuration is captured only while reset is held (R11)
    always_ff @(posedge clk) begin
        if (rst) begin
            own_q.row <= cfg_row;
            own_q.col <= cfg_col;
            side_q    <= side_flags;
            en_q      <= link_en;
        end
    end

    port_e dir;
    logic  offchip;
    logic  drop;
    logic  stage_ready;
    logic  accept;

    mrs_decide u_decide (
        .own  (own_q),
        .addr (in_addr),
        .dir  (dir)
    );

    mrs_link_gate u_gate (
        .dir     (dir),
        .side_q  (side_q),
        .en_q    (en_q),
        .offchip (offchip),
        .drop    (drop)
    );

    assign in_ready = !rst && stage_ready;
    assign accept   = in_valid && in_ready;

    mrs_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .load        (accept && !drop),
        .dir         (dir),
        .addr        (in_addr),
        .wr          (in_write),
        .data        (in_data),
        .offchip     (offchip),
        .out_ready   (out_ready),
        .ready       (stage_ready),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_write   (out_write),
        .out_data    (out_data),
        .out_offchip (out_offchip)
    );

    mrs_drop_ctr #(.CNT_W(CNT_W)) u_drop (
        .clk  (clk),
        .rst  (rst),
        .bump (accept && drop),
        .cnt  (drop_count)
    );

    assert_local_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid[PORT_L] |-> (addr_coord(out_addr) == own_q));

    assert_east_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid[PORT_E] |-> (addr_coord(out_addr).col > own_q.col));

    assert_vertical_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid[PORT_N] || out_valid[PORT_S]) |-> (addr_coord(out_addr).col == own_q.col));

    assert_no_dead_link_R9: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> ((out_valid[NSIDE-1:0] & side_q & ~en_q) == '0));

    assert_offchip_R8: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> (out_offchip == (|(out_valid[NSIDE-1:0] & side_q))));
endmodule

// File: tb/mesh_route_sel_tb.sv
module mesh_route_sel_tb;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 0;
    logic          rst = 1;
    logic [5:0]    cfg_row = 0, cfg_col = 0;
    logic [3:0]    side_flags = 0, link_en = 0;
    logic          in_valid = 0, in_write = 0;
    logic          in_ready;
    logic [31:0]   in_addr = 0;
    logic [DW-1:0] in_data = 0;
    logic [4:0]    out_valid, out_ready = 0;
    logic [31:0]   out_addr;
    logic          out_write, out_offchip;
    logic [DW-1:0] out_data;
    logic [CW-1:0] drop_count;

    always #5 clk = ~clk;

    mesh_route_sel #(.DATA_W(DW), .CNT_W(CW)) u_dut (.*);

    int errors = 0, checks = 0;
    bit done = 0;
    logic [31:0] rnd = 32'h1234_5678;

    // reference model state
    int m_row, m_col;
    logic [3:0] m_side, m_en;
    bit m_v; int m_port;
    logic [31:0] m_addr; logic m_wr; logic [DW-1:0] m_data; logic m_off;
    int m_cnt;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic roll();
        rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
    endtask

    function automatic int exp_port(logic [31:0] a);
        int r = a[31:26]; int c = a[25:20];
        if (c > m_col) return 2;
        if (c < m_col) return 3;
        if (r < m_row) return 0;
        if (r > m_row) return 1;
        return 4;
    endfunction

    task automatic check_state(string tag);
        chk(tag, "out_valid", out_valid, m_v ? (5'b1 << m_port) : 5'b0);
        chk(tag, "drop_count", drop_count, m_cnt);
        if (m_v) begin
            chk(tag, "out_addr", out_addr, m_addr);
            chk(tag, "out_data", out_data, m_data);
            chk(tag, "out_write", out_write, m_wr);
            chk(tag, "out_offchip", out_offchip, m_off);
        end
    endtask

    task automatic step(string tag, bit iv, logic [31:0] a, logic [4:0] ordy);
        bit rdy, fire;
        int p;
        @(negedge clk);
        check_state(tag);
        in_valid  = iv;
        in_addr   = a;
        in_write  = rnd[3];
        in_data   = rnd ^ 32'hA5A5_0F0F;
        out_ready = ordy;
        #1;
        fire = m_v && ordy[m_port];
        rdy  = !m_v || fire;
        chk(tag, "in_ready", in_ready, rdy);
        if (iv && rdy) begin
            p = exp_port(a);
            if (p < 4 && m_side[p] && !m_en[p]) begin
                m_cnt++;
                m_v = 0;
            end else begin
                m_v = 1; m_port = p; m_addr = a; m_wr = in_write;
                m_data = in_data; m_off = (p < 4) && m_side[p];
            end
        end else if (fire) m_v = 0;
    endtask

    task automatic do_reset(int r, int c, logic [3:0] s, logic [3:0] e);
        @(negedge clk);
        rst = 1; in_valid = 0;
        cfg_row = r[5:0]; cfg_col = c[5:0]; side_flags = s; link_en = e;
        repeat (3) @(negedge clk);
        chk("R12", "out_valid", out_valid, 0);
        chk("R12", "drop_count", drop_count, 0);
        chk("R12", "in_ready", in_ready, 0);
        rst = 0;
        m_row = r; m_col = c; m_side = s; m_en = e; m_v = 0; m_cnt = 0;
        // pins move after reset: must be ignored (R11)
        cfg_row = ~r[5:0]; cfg_col = ~c[5:0]; side_flags = ~s; link_en = ~e;
    endtask

    function automatic logic [31:0] mk(int r, int c);
        return {r[5:0], c[5:0], rnd[19:0]};
    endfunction

    task automatic rand_phase(string tag, int n);
        for (int i = 0; i < n; i++) begin
            int r, c;
            roll();
            r = (rnd[5:4] == 0) ? int'(rnd[13:8]) : m_row + int'(rnd[7:6]) - 1;
            c = (rnd[10:9] == 0) ? int'(rnd[21:16]) : m_col + int'(rnd[12:11]) - 1;
            step(tag, rnd[22] | rnd[23], mk(r, c), rnd[28:24] | {5{rnd[29]}});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(5, 9, 4'b0000, 4'b0000);
        step("R1", 1, mk(0, 20), 5'h1f);
        step("R1", 1, mk(63, 3), 5'h1f);
        step("R2", 1, mk(2, 9), 5'h1f);
        step("R2", 1, mk(40, 9), 5'h1f);
        step("R3", 1, mk(5, 9), 5'h1f);
        step("R10", 1, mk(5, 10), 5'h1f);
        step("R6", 1, mk(5, 30), 5'h00);
        for (int i = 0; i < 4; i++) step("R6", 1, mk(1, 9), 5'h1b);
        step("R6", 1, mk(1, 9), 5'h04);
        step("R7", 1, mk(9, 9), 5'h1f);
        step("R7", 1, mk(5, 9), 5'h1f);
        step("R7", 0, 0, 5'h1f);
        rand_phase("R4", 800);
        rand_phase("R5", 400);
        rand_phase("R11", 200);

        // corner node: north and east are chip boundaries, north link absent
        do_reset(0, 63, 4'b0101, 4'b0100);
        step("R8", 1, mk(9, 63), 5'h1f);
        step("R8", 1, mk(9, 10), 5'h1f);
        step("R9", 0, 0, 5'h1f);
        do_reset(7, 63, 4'b0101, 4'b0100);
        step("R9", 1, mk(2, 63), 5'h1f);
        step("R9", 0, 0, 5'h00);
        step("R9", 1, mk(8, 63), 5'h00);
        step("R9", 1, mk(1, 63), 5'h02);
        step("R9", 0, 0, 5'h1f);
        rand_phase("R9", 1000);
        do_reset(30, 0, 4'b1010, 4'b0010);
        step("R8", 1, mk(30, 50), 5'h1f);
        step("R10", 1, mk(40, 0), 5'h1f);
        rand_phase("R8", 1000);
        step("R12", 0, 0, 5'h1f);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule